// File: doc/BRIEF.md
# CAN Fault-Confinement Flag Unit

This block watches the transmit and receive error counters of one CAN channel and works out whether the channel is error-active, error-passive or bus-off. It raises five sticky status flags for software:
- **warning crossing**
- **passive crossing**
- **bus-off entry**
- **bus-off recovery**
- **protocol error**

Each flag stays set until software writes a zero to it through a per-flag clear strobe. The counters themselves are maintained elsewhere. The transmit counter input is wide enough to show values above 255.

While the channel is bus-off, the unit counts strobes that each report 11 consecutive recessive bits. Software can end bus-off early in three ways: a channel reset, a forced return, or a halt. The halt takes effect according to a two-bit bus-off handling mode. A recovery flag is raised only when bus-off ends through the full count of recessive-bit detections. It is never raised on a software-forced exit.

All outputs are registered. They reflect the inputs seen at the previous rising clock edge.

Top module: `can_fault_flags`

## Requirements
- R1: While `rst_n` is low at a rising edge, every flag clears, `chan_state` becomes 00 and the recovery count returns to zero.
- R2: Outside bus-off, `chan_state` shows 01 (passive) one cycle after either counter is above 127 with `tec` at most 255, and 00 (active) otherwise; 10 means bus-off and 11 never appears.
- R3: `flag_warn` sets one cycle after the condition "`tec` > 95 or `rec` > 95" turns from false to true.
- R4: If `flag_warn` is cleared while that condition still holds, it stays clear until both counters have been at or below 95 and one of them then exceeds 95 again.
- R5: `flag_pass` follows the same first-crossing and re-arm rule as R3 and R4 with the limit 127.
- R6: When `tec` exceeds 255 while the channel is not bus-off, `chan_state` becomes 10 and `flag_boff_entry` sets on the next cycle, whatever the handling mode.
- R7: In bus-off with `boff_mode` 00, 10 or 11, the 128th `recess_det` strobe since entry returns `chan_state` to 00 and sets `flag_boff_rcv`. Strobes outside bus-off are ignored.
- R8: A `req_reset` or `req_force_ret` pulse during bus-off returns `chan_state` to 00 on the next cycle. It clears the recovery count and does not set `flag_boff_rcv`.
- R9: With `boff_mode` 01 (halt at entry), bus-off ends one cycle after it was entered, to state 00, without setting `flag_boff_rcv`.
- R10: With `boff_mode` 11, a `req_halt` pulse during bus-off acts as a forced exit as in R8. With `boff_mode` 00, `req_halt` leaves the channel in bus-off.
- R11: `flag_bus_err` sets one cycle after any bit of `err_src` is high. The bits are [0] ACK delimiter, [1] bit-0, [2] bit-1, [3] CRC, [4] ACK, [5] form and [6] stuff error.
- R12: Every flag holds its value until its clear strobe is high. When a clear and a set event arrive in the same cycle, the flag ends up set.
- R13: A forced exit in the same cycle as the 128th strobe takes priority, so `flag_boff_rcv` stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tec | input | TEC_W (9) | Transmit error counter value |
| rec | input | REC_W (8) | Receive error counter value |
| recess_det | input | 1 | Pulse per detection of 11 consecutive recessive bits |
| req_reset | input | 1 | Channel reset request |
| req_halt | input | 1 | Channel halt request |
| req_force_ret | input | 1 | Forced return from bus-off |
| boff_mode | input | 2 | Bus-off handling: 00 auto, 01 halt at entry, 10 auto, 11 halt on request |
| err_src | input | ERR_N (7) | Individual protocol-error pulses |
| clr_warn | input | 1 | Write-zero strobe for the warning flag |
| clr_pass | input | 1 | Write-zero strobe for the passive flag |
| clr_boff_entry | input | 1 | Write-zero strobe for the bus-off entry flag |
| clr_boff_rcv | input | 1 | Write-zero strobe for the recovery flag |
| clr_bus_err | input | 1 | Write-zero strobe for the protocol-error flag |
| flag_warn | output | 1 | Warning-limit crossing flag |
| flag_pass | output | 1 | Passive-limit crossing flag |
| flag_boff_entry | output | 1 | Bus-off entry flag |
| flag_boff_rcv | output | 1 | Bus-off recovery flag |
| flag_bus_err | output | 1 | Protocol error flag |
| chan_state | output | 2 | 00 active, 01 passive, 10 bus-off |

## Verification
The assertions check the following on every cycle:
- the reset values and that the state encoding stays legal;
- that bus-off entry follows a transmit count above 255;
- that a forced exit never raises the recovery flag;
- that a rising recovery flag is always preceded by exactly 127 earlier strobes in the current bus-off period;
- that protocol errors and warning crossings leave sticky flags.

Only the bench's scenarios can show the following:
- the re-arm rule after a clear while a counter stays high;
- that strobes outside bus-off do not shorten the next recovery;
- how the three handling modes treat halt requests;
- the priority of a forced exit over the final strobe.

An exhaustive sweep over both counters compares the state and both crossing flags with values computed arithmetically.

// File: rtl/cff_pkg.sv
package cff_pkg;

   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'b00,
      ST_PASSIVE = 2'b01,
      ST_BUSOFF  = 2'b10
   } cff_state_e;

   typedef enum logic [1:0] {
      BOM_AUTO       = 2'b00,
      BOM_HALT_ENTRY = 2'b01,
      BOM_AUTO_ALT   = 2'b10,
      BOM_HALT_REQ   = 2'b11
   } cff_bomode_e;

   localparam int NUM_FLAGS = 5;
   localparam int FL_WARN   = 0;
   localparam int FL_PASS   = 1;
   localparam int FL_ENTRY  = 2;
   localparam int FL_RCV    = 3;
   localparam int FL_BERR   = 4;

endpackage

// File: rtl/cff_sticky_flag.sv
module cff_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   // set has priority over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= set_i | (flag_o & ~clr_i);
   end

endmodule

// File: rtl/cff_cross_det.sv
module cff_cross_det #(
   parameter int TEC_W = 9,
   parameter int REC_W = 8,
   parameter int LIMIT = 95
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TEC_W-1:0] tec_i,
   input  logic [REC_W-1:0] rec_i,
   output logic             rise_o
);

   localparam logic [TEC_W-1:0] TEC_LIM = TEC_W'(LIMIT);
   localparam logic [REC_W-1:0] REC_LIM = REC_W'(LIMIT);

   if (LIMIT < 0 || LIMIT >= (2 ** REC_W) - 1) begin : g_bad_limit
      $error("cff_cross_det: LIMIT out of counter range");
   end

   logic above;
   logic above_q;

   assign above = (tec_i > TEC_LIM) || (rec_i > REC_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) above_q <= 1'b0;
      else        above_q <= above;
   end

   // one event per excursion above the limit; re-armed once both fall back
   assign rise_o = above & ~above_q;

endmodule

// File: rtl/cff_err_merge.sv
module cff_err_merge #(
   parameter int ERR_N = 7
) (
   input  logic [ERR_N-1:0] err_i,
   output logic             any_o
);

   if (ERR_N < 1) begin : g_bad_n
      $error("cff_err_merge: ERR_N must be at least 1");
   end

   logic [ERR_N:0] chain;
   assign chain[0] = 1'b0;

   for (genvar i = 0; i < ERR_N; i++) begin : g_or
      assign chain[i+1] = chain[i] | err_i[i];
   end

   assign any_o = chain[ERR_N];

endmodule

// File: rtl/cff_busoff_ctl.sv
module cff_busoff_ctl
   import cff_pkg::*;
#(
   parameter int TEC_W    = 9,
   parameter int REC_W    = 8,
   parameter int PASS_LIM = 127,
   parameter int BOFF_LIM = 255,
   parameter int RECOV_N  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TEC_W-1:0] tec_i,
   input  logic [REC_W-1:0] rec_i,
   input  logic             recess_i,
   input  logic             req_reset_i,
   input  logic             req_halt_i,
   input  logic             req_force_i,
   input  cff_bomode_e      mode_i,
   output cff_state_e       state_o,
   output logic             entry_o,
   output logic             rcv_o
);

   localparam int               CNT_W     = $clog2(RECOV_N);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(RECOV_N - 1);
   localparam logic [TEC_W-1:0] TEC_BOFF  = TEC_W'(BOFF_LIM);
   localparam logic [TEC_W-1:0] TEC_PASS  = TEC_W'(PASS_LIM);
   localparam logic [REC_W-1:0] REC_PASS  = REC_W'(PASS_LIM);

   if (RECOV_N < 2) begin : g_bad_recov
      $error("cff_busoff_ctl: RECOV_N must be at least 2");
   end
   if (BOFF_LIM >= (2 ** TEC_W) - 1) begin : g_bad_tec
      $error("cff_busoff_ctl: TEC_W too narrow to exceed BOFF_LIM");
   end
   if (PASS_LIM >= BOFF_LIM) begin : g_bad_order
      $error("cff_busoff_ctl: PASS_LIM must lie below BOFF_LIM");
   end

   cff_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             forced;
   logic             last_det;

   // software-driven ways out of bus-off
   assign forced = req_reset_i | req_force_i
                 | (mode_i == BOM_HALT_ENTRY)
                 | ((mode_i == BOM_HALT_REQ) & req_halt_i);

   assign last_det = recess_i & (cnt_q == CNT_LAST);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      entry_o = 1'b0;
      rcv_o   = 1'b0;
      if (state_q == ST_BUSOFF) begin
         if (forced) begin
            state_d = ST_ACTIVE;
            cnt_d   = '0;
         end else if (last_det) begin
            state_d = ST_ACTIVE;
            cnt_d   = '0;
            rcv_o   = 1'b1;
         end else if (recess_i) begin
            cnt_d   = cnt_q + 1'b1;
         end
      end else begin
         cnt_d = '0;
         if (tec_i > TEC_BOFF) begin
            state_d = ST_BUSOFF;
            entry_o = 1'b1;
         end else if ((tec_i > TEC_PASS) || (rec_i > REC_PASS)) begin
            state_d = ST_PASSIVE;
         end else begin
            state_d = ST_ACTIVE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_ACTIVE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags
   import cff_pkg::*;
#(
   parameter int TEC_W    = 9,
   parameter int REC_W    = 8,
   parameter int WARN_LIM = 95,
   parameter int PASS_LIM = 127,
   parameter int BOFF_LIM = 255,
   parameter int RECOV_N  = 128,
   parameter int ERR_N    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TEC_W-1:0] tec,
   input  logic [REC_W-1:0] rec,
   input  logic             recess_det,
   input  logic             req_reset,
   input  logic             req_halt,
   input  logic             req_force_ret,
   input  logic [1:0]       boff_mode,
   input  logic [ERR_N-1:0] err_src,
   input  logic             clr_warn,
   input  logic             clr_pass,
   input  logic             clr_boff_entry,
   input  logic             clr_boff_rcv,
   input  logic             clr_bus_err,
   output logic             flag_warn,
   output logic             flag_pass,
   output logic             flag_boff_entry,
   output logic             flag_boff_rcv,
   output logic             flag_bus_err,
   output logic [1:0]       chan_state
);

   if (WARN_LIM >= PASS_LIM) begin : g_bad_lims
      $error("can_fault_flags: WARN_LIM must lie below PASS_LIM");
   end

   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] clr_v;
   logic [NUM_FLAGS-1:0] flag_v;
   logic [1:0]           cross_v;
   cff_state_e           state;

   // crossing detectors: index 0 warning limit, index 1 passive limit
   for (genvar g = 0; g < 2; g++) begin : g_cross
      localparam int LIM = (g == 0) ? WARN_LIM : PASS_LIM;
      cff_cross_det #(
         .TEC_W (TEC_W),
         .REC_W (REC_W),
         .LIMIT (LIM)
      ) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .tec_i  (tec),
         .rec_i  (rec),
         .rise_o (cross_v[g])
      );
   end

   cff_busoff_ctl #(
      .TEC_W    (TEC_W),
      .REC_W    (REC_W),
      .PASS_LIM (PASS_LIM),
      .BOFF_LIM (BOFF_LIM),
      .RECOV_N  (RECOV_N)
   ) u_boff (
      .clk         (clk),
      .rst_n       (rst_n),
      .tec_i       (tec),
      .rec_i       (rec),
      .recess_i    (recess_det),
      .req_reset_i (req_reset),
      .req_halt_i  (req_halt),
      .req_force_i (req_force_ret),
      .mode_i      (cff_bomode_e'(boff_mode)),
      .state_o     (state),
      .entry_o     (set_v[FL_ENTRY]),
      .rcv_o       (set_v[FL_RCV])
   );

   cff_err_merge #(
      .ERR_N (ERR_N)
   ) u_err (
      .err_i (err_src),
      .any_o (set_v[FL_BERR])
   );

   assign set_v[FL_WARN] = cross_v[0];
   assign set_v[FL_PASS] = cross_v[1];

   assign clr_v[FL_WARN]  = clr_warn;
   assign clr_v[FL_PASS]  = clr_pass;
   assign clr_v[FL_ENTRY] = clr_boff_entry;
   assign clr_v[FL_RCV]   = clr_boff_rcv;
   assign clr_v[FL_BERR]  = clr_bus_err;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      cff_sticky_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[f]),
         .clr_i  (clr_v[f]),
         .flag_o (flag_v[f])
      );
   end

   assign flag_warn       = flag_v[FL_WARN];
   assign flag_pass       = flag_v[FL_PASS];
   assign flag_boff_entry = flag_v[FL_ENTRY];
   assign flag_boff_rcv   = flag_v[FL_RCV];
   assign flag_bus_err    = flag_v[FL_BERR];
   assign chan_state      = state;

endmodule

// File: rtl/cff_flags_chk.sv
module cff_flags_chk #(
   parameter int TEC_W    = 9,
   parameter int REC_W    = 8,
   parameter int WARN_LIM = 95,
   parameter int BOFF_LIM = 255,
   parameter int RECOV_N  = 128,
   parameter int ERR_N    = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TEC_W-1:0] tec,
   input logic [REC_W-1:0] rec,
   input logic             recess_det,
   input logic             req_reset,
   input logic             req_force_ret,
   input logic [ERR_N-1:0] err_src,
   input logic             clr_warn,
   input logic             clr_bus_err,
   input logic             flag_warn,
   input logic             flag_pass,
   input logic             flag_boff_entry,
   input logic             flag_boff_rcv,
   input logic             flag_bus_err,
   input logic [1:0]       chan_state
);

   localparam int               CW       = $clog2(RECOV_N) + 1;
   localparam logic [TEC_W-1:0] T_BOFF   = TEC_W'(BOFF_LIM);
   localparam logic [TEC_W-1:0] T_WARN   = TEC_W'(WARN_LIM);
   localparam logic [REC_W-1:0] R_WARN   = REC_W'(WARN_LIM);
   localparam logic [CW-1:0]    CNT_LAST = CW'(RECOV_N - 1);

   // strobes seen in the current bus-off period
   logic [CW-1:0] det_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                   det_cnt <= '0;
      else if (chan_state != 2'b10) det_cnt <= '0;
      else if (recess_det)          det_cnt <= det_cnt + 1'b1;
   end

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (chan_state == 2'b00 && !flag_warn && !flag_pass &&
                  !flag_boff_entry && !flag_boff_rcv && !flag_bus_err));

   a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      chan_state != 2'b11);

   a_r3_warn_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_warn) |-> $past((tec > T_WARN) || (rec > R_WARN)));

   a_r6_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_state != 2'b10 && tec > T_BOFF) |=> (chan_state == 2'b10 && flag_boff_entry));

   a_r7_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_boff_rcv) |-> ($past(chan_state) == 2'b10 && $past(recess_det) &&
                                $past(det_cnt) == CNT_LAST));

   a_r8_forced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_state == 2'b10 && (req_reset || req_force_ret) && !flag_boff_rcv)
      |=> (chan_state == 2'b00 && !flag_boff_rcv));

   a_r11_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_src) |=> flag_bus_err);

   a_r12_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_warn && !clr_warn) |=> flag_warn);

   a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_bus_err && !clr_bus_err) |=> flag_bus_err);

endmodule

bind can_fault_flags cff_flags_chk #(
   .TEC_W    (TEC_W),
   .REC_W    (REC_W),
   .WARN_LIM (WARN_LIM),
   .BOFF_LIM (BOFF_LIM),
   .RECOV_N  (RECOV_N),
   .ERR_N    (ERR_N)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .tec             (tec),
   .rec             (rec),
   .recess_det      (recess_det),
   .req_reset       (req_reset),
   .req_force_ret   (req_force_ret),
   .err_src         (err_src),
   .clr_warn        (clr_warn),
   .clr_bus_err     (clr_bus_err),
   .flag_warn       (flag_warn),
   .flag_pass       (flag_pass),
   .flag_boff_entry (flag_boff_entry),
   .flag_boff_rcv   (flag_boff_rcv),
   .flag_bus_err    (flag_bus_err),
   .chan_state      (chan_state)
);

// File: tb/can_fault_flags_test.sv
module can_fault_flags_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] tec = '0;
   logic [7:0] rec = '0;
   logic       recess_det = 1'b0;
   logic       req_reset = 1'b0;
   logic       req_halt = 1'b0;
   logic       req_force_ret = 1'b0;
   logic [1:0] boff_mode = 2'b00;
   logic [6:0] err_src = '0;
   logic       clr_warn = 1'b0;
   logic       clr_pass = 1'b0;
   logic       clr_boff_entry = 1'b0;
   logic       clr_boff_rcv = 1'b0;
   logic       clr_bus_err = 1'b0;
   logic       flag_warn, flag_pass, flag_boff_entry, flag_boff_rcv, flag_bus_err;
   logic [1:0] chan_state;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;   // 50 MHz

   can_fault_flags uut (
      .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec), .recess_det(recess_det),
      .req_reset(req_reset), .req_halt(req_halt), .req_force_ret(req_force_ret),
      .boff_mode(boff_mode), .err_src(err_src), .clr_warn(clr_warn),
      .clr_pass(clr_pass), .clr_boff_entry(clr_boff_entry),
      .clr_boff_rcv(clr_boff_rcv), .clr_bus_err(clr_bus_err),
      .flag_warn(flag_warn), .flag_pass(flag_pass),
      .flag_boff_entry(flag_boff_entry), .flag_boff_rcv(flag_boff_rcv),
      .flag_bus_err(flag_bus_err), .chan_state(chan_state)
   );

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_all();
      clr_warn = 1; clr_pass = 1; clr_boff_entry = 1; clr_boff_rcv = 1; clr_bus_err = 1;
      tick();
      clr_warn = 0; clr_pass = 0; clr_boff_entry = 0; clr_boff_rcv = 0; clr_bus_err = 0;
   endtask

   task automatic strobes(input int n);
      recess_det = 1;
      repeat (n) tick();
      recess_det = 0;
   endtask

   task automatic enter_busoff();
      tec = 9'd300; tick();
      tec = 9'd0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      bit exp_w, exp_p, prev_w, prev_p;
      tick(); tick();
      // R1: state and flags under reset
      check("R1", "state", chan_state, 0);
      check("R1", "flags", {flag_warn, flag_pass, flag_boff_entry, flag_boff_rcv, flag_bus_err}, 0);
      rst_n = 1; tick();

      // R2/R3/R5: sweep both counters
      exp_w = 0; exp_p = 0; prev_w = 0; prev_p = 0;
      for (int r = 0; r < 256; r += 5) begin
         for (int t = 0; t < 256; t++) begin
            bit aw, ap;
            tec = 9'(t); rec = 8'(r);
            tick();
            aw = (t > 95) || (r > 95);
            ap = (t > 127) || (r > 127);
            if (aw && !prev_w) exp_w = 1;
            if (ap && !prev_p) exp_p = 1;
            prev_w = aw; prev_p = ap;
            check("R2", "state sweep", chan_state, ap ? 1 : 0);
            check("R3", "warn sweep", flag_warn, exp_w);
            check("R5", "pass sweep", flag_pass, exp_p);
         end
      end

      // R4: warning re-arm
      tec = 0; rec = 0; tick(); clear_all();
      rec = 100; tick();
      check("R3", "warn on crossing", flag_warn, 1);
      clr_warn = 1; tick(); clr_warn = 0;
      check("R12", "warn cleared", flag_warn, 0);
      rec = 120; tick();
      check("R4", "no reset while high", flag_warn, 0);
      tec = 50; tick();
      check("R4", "still high", flag_warn, 0);
      rec = 95; tec = 95; tick();
      check("R4", "both at limit", flag_warn, 0);
      tec = 96; tick();
      check("R4", "re-armed crossing", flag_warn, 1);

      // R5: passive re-arm
      tec = 0; rec = 0; tick(); clear_all();
      rec = 130; tick();
      check("R5", "pass on crossing", flag_pass, 1);
      clr_pass = 1; tick(); clr_pass = 0;
      tec = 200; tick();
      check("R5", "no reset while high", flag_pass, 0);
      tec = 0; rec = 127; tick();
      tec = 128; tick();
      check("R5", "re-armed crossing", flag_pass, 1);
      tec = 0; rec = 0; tick(); clear_all();

      // R12: set wins, hold
      err_src = 7'b0000001; clr_bus_err = 1; tick();
      err_src = 0; clr_bus_err = 0;
      check("R12", "set beats clear", flag_bus_err, 1);
      repeat (3) tick();
      check("R12", "hold without clear", flag_bus_err, 1);
      clr_bus_err = 1; tick(); clr_bus_err = 0;
      check("R12", "clear", flag_bus_err, 0);

      // R11: every source
      for (int i = 0; i < 7; i++) begin
         err_src = 7'(1 << i); tick(); err_src = 0;
         check("R11", $sformatf("source %0d", i), flag_bus_err, 1);
         clr_bus_err = 1; tick(); clr_bus_err = 0;
      end
      repeat (2) tick();
      check("R11", "quiet sources", flag_bus_err, 0);

      // R6/R7: automatic recovery, idle strobes ignored
      boff_mode = 2'b00; clear_all();
      strobes(200);
      check("R7", "strobes outside bus-off", chan_state, 0);
      enter_busoff();
      check("R6", "enter state", chan_state, 2);
      check("R6", "entry flag", flag_boff_entry, 1);
      strobes(127);
      check("R7", "after 127", chan_state, 2);
      check("R7", "no flag after 127", flag_boff_rcv, 0);
      strobes(1);
      check("R7", "after 128 state", chan_state, 0);
      check("R7", "after 128 flag", flag_boff_rcv, 1);

      // R7 with mode 10
      boff_mode = 2'b10; clear_all(); enter_busoff();
      strobes(128);
      check("R7", "mode 10 recovery", flag_boff_rcv, 1);

      // R8: forced return, counter cleared
      boff_mode = 2'b00; clear_all(); enter_busoff();
      strobes(100);
      req_force_ret = 1; tick(); req_force_ret = 0;
      check("R8", "forced state", chan_state, 0);
      check("R8", "forced no flag", flag_boff_rcv, 0);
      enter_busoff();
      strobes(127);
      check("R8", "count restarted", chan_state, 2);
      strobes(1);
      check("R8", "full count after restart", flag_boff_rcv, 1);
      clear_all(); enter_busoff();
      strobes(50);
      req_reset = 1; tick(); req_reset = 0;
      check("R8", "reset exit state", chan_state, 0);
      check("R8", "reset exit no flag", flag_boff_rcv, 0);

      // R10: halt request by mode
      boff_mode = 2'b11; clear_all(); enter_busoff();
      req_halt = 1; tick(); req_halt = 0;
      check("R10", "halt mode 11 state", chan_state, 0);
      check("R10", "halt mode 11 no flag", flag_boff_rcv, 0);
      boff_mode = 2'b00; enter_busoff();
      req_halt = 1; tick(); req_halt = 0;
      check("R10", "halt mode 00 ignored", chan_state, 2);
      req_force_ret = 1; tick(); req_force_ret = 0;

      // R9: halt at entry
      boff_mode = 2'b01; clear_all(); enter_busoff();
      check("R9", "entered", chan_state, 2);
      check("R6", "entry flag mode 01", flag_boff_entry, 1);
      tick();
      check("R9", "left next cycle", chan_state, 0);
      check("R9", "no recovery flag", flag_boff_rcv, 0);

      // R13: forced exit with the 128th strobe
      boff_mode = 2'b00; clear_all(); enter_busoff();
      strobes(127);
      recess_det = 1; req_force_ret = 1; tick();
      recess_det = 0; req_force_ret = 0;
      check("R13", "state", chan_state, 0);
      check("R13", "no recovery flag", flag_boff_rcv, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule